// File: doc/BRIEF.md
# Mixed-Depth Pixel Plane Selector

This block is the last stage before a display surface. It consumes one scan line as a stream of pixels. Each pixel arrives as three words: an 8-bit colour index, a 32-bit direct-colour word and a 32-bit control word. For every pixel the control word picks one of two sources. The first is the index looked up in an external 256-entry colour table. The second is the 24-bit colour held in the direct word. The chosen colour leaves as a 32-bit pixel on a valid/ready stream, in either red-first or blue-first byte order.

The colour table sits outside the block. The block presents an index on a lookup port and takes the table's {R,G,B} answer in the same cycle. The upstream memory always advances a full 1024-pixel stride per line. Only the visible pixels of each line are streamed in, and the block marks the last visible one. A two-register pipeline holds the accepted inputs and then the formatted pixel. Both registers stall under output backpressure without losing or repeating a pixel.

Top module: `pix_plane_mixer`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A pixel takes the direct path exactly when bits [31:24] of `in_ctrl` equal 8'h03. Bits [23:0] of `in_ctrl` have no effect on the output.
- R3: When bits [31:24] of `in_ctrl` hold any value other than 8'h03, `pal_addr` carries the pixel's `in_index`, and the output colour is the {R,G,B} that `pal_rgb` returns (R in [23:16], G in [15:8], B in [7:0]).
- R4: On the direct path, red is `in_direct[7:0]`, green is `in_direct[15:8]` and blue is `in_direct[23:16]`. Bits [31:24] of `in_direct` are ignored.
- R5: With `cfg_bgr`=0 the output pixel is {8'h00,R,G,B}. With `cfg_bgr`=1 it is {8'h00,B,G,R}.
- R6: Bits [31:24] of every valid output pixel are zero.
- R7: `out_eol` is 1 on the pixel whose position in the line equals the visible width. The position then restarts at the first pixel. With width 1, every pixel carries `out_eol`.
- R8: A `cfg_width` of 0 or above 1024 is treated as 1024.
- R9: A pixel accepted at one rising edge becomes visible on the output after the following rising edge. With `out_ready` held high, one pixel is accepted every cycle.
- R10: While `out_valid`=1 and `out_ready`=0, the output pixel and `out_eol` hold. Once both pipeline registers are full and stalled, `in_ready` is 0. No pixel is dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bgr | input | 1 | 1 selects blue-first output byte order |
| cfg_width | input | 11 | Visible pixels per line (0 or >1024 means 1024) |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_index | input | 8 | Colour index for the table path |
| in_direct | input | 32 | Direct colour word, blue/green/red in bytes [23:16]/[15:8]/[7:0] |
| in_ctrl | input | 32 | Control word; bits [31:24] select the source |
| pal_addr | output | 8 | Colour table lookup index |
| pal_rgb | input | 24 | Colour table answer {R,G,B}, same cycle |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pixel | output | 32 | Formatted pixel, top byte zero |
| out_eol | output | 1 | Last visible pixel of the line |

## Verification
A wrong line-position count shows first as an end-of-line mark on the wrong pixel, or a missing one, within a single line. A mark at width 1 or at the 1024 clamp points straight at the limit logic. A wrong stage-valid or enable shows at the next stalled handshake as a lost, repeated or changing output pixel, so irregular ready and valid patterns are used to expose it within a few cycles. A wrong source decode or byte placement corrupts the very next pixel of that kind. The tag byte is therefore swept over all 256 values in both byte orders.

// File: rtl/pix_mix_pkg.sv
package pix_mix_pkg;

  localparam int CH_W  = 8;
  localparam int PIX_W = 32;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  // Place the three channels into a display word; top byte always zero.
  function automatic logic [PIX_W-1:0] pack_pixel(rgb_t c, logic bgr);
    if (bgr) return {8'h00, c.b, c.g, c.r};
    return {8'h00, c.r, c.g, c.b};
  endfunction

  // Direct word holds blue in [23:16], green in [15:8], red in [7:0].
  function automatic rgb_t unpack_direct(logic [23:0] w);
    rgb_t c;
    c.b = w[23:16];
    c.g = w[15:8];
    c.r = w[7:0];
    return c;
  endfunction

endpackage

// File: rtl/pix_line_pos.sv
module pix_line_pos #(
  parameter int MAX_W = 1024
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(MAX_W):0]   cfg_width,
  input  logic                     adv,
  output logic                     last
);
  localparam int PW = $clog2(MAX_W);
  localparam int WW = PW + 1;

  logic [PW-1:0] pos;
  logic [WW-1:0] lim_m1;

  // Out-of-range widths fall back to the full stride.
  always_comb begin
    if (cfg_width == '0 || cfg_width > WW'(MAX_W)) lim_m1 = WW'(MAX_W - 1);
    else                                           lim_m1 = cfg_width - 1'b1;
  end

  // ">=" also closes a line if the width shrinks mid-line.
  assign last = ({1'b0, pos} >= lim_m1);

  always_ff @(posedge clk) begin
    if (rst)      pos <= '0;
    else if (adv) pos <= last ? '0 : pos + 1'b1;
  end

  AST_POS_RESTART: assert property (@(posedge clk) disable iff (rst)
    adv && last |=> pos == '0);                                      // R7
  AST_POS_STEP: assert property (@(posedge clk) disable iff (rst)
    adv && !last |=> pos == $past(pos) + 1'b1);                      // R7

endmodule

// File: rtl/pix_in_stage.sv
module pix_in_stage #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_idx,
  input  logic [23:0]      in_rgb_word,
  input  logic [7:0]       in_tag,
  input  logic             in_eol,
  input  logic             down_en,
  output logic             s1_valid,
  output logic [IDX_W-1:0] s1_idx,
  output logic [23:0]      s1_rgb_word,
  output logic [7:0]       s1_tag,
  output logic             s1_eol
);

  assign in_ready = !s1_valid || down_en;

  always_ff @(posedge clk) begin
    if (rst)           s1_valid <= 1'b0;
    else if (in_ready) s1_valid <= in_valid;
  end

  // Data registers carry no reset so they map onto plain flops.
  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      s1_idx      <= in_idx;
      s1_rgb_word <= in_rgb_word;
      s1_tag      <= in_tag;
      s1_eol      <= in_eol;
    end
  end

  AST_S1_HOLD: assert property (@(posedge clk) disable iff (rst)
    s1_valid && !down_en |=> s1_valid && $stable(s1_idx) && $stable(s1_tag)
                             && $stable(s1_rgb_word) && $stable(s1_eol)); // R10

endmodule

// File: rtl/pix_sel_stage.sv
module pix_sel_stage
  import pix_mix_pkg::*;
#(
  parameter logic [7:0] DIRECT_TAG = 8'h03
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_valid,
  input  logic [7:0]       up_tag,
  input  logic [23:0]      up_rgb_word,
  input  logic             up_eol,
  input  rgb_t             pal_rgb,
  input  logic             cfg_bgr,
  output logic             down_en,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pixel,
  output logic             out_eol
);

  logic             use_direct;
  rgb_t             pick;
  logic [PIX_W-1:0] nxt_pixel;
  logic             load;

  assign down_en    = !out_valid || out_ready;
  assign load       = up_valid && down_en;
  assign use_direct = (up_tag == DIRECT_TAG);
  assign pick       = use_direct ? unpack_direct(up_rgb_word) : pal_rgb;
  assign nxt_pixel  = pack_pixel(pick, cfg_bgr);

  always_ff @(posedge clk) begin
    if (rst)          out_valid <= 1'b0;
    else if (down_en) out_valid <= up_valid;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_pixel <= nxt_pixel;
      out_eol   <= up_eol;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pixel) && $stable(out_eol)); // R10
  AST_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_pixel[31:24] == 8'h00);                                         // R6
  AST_DIRECT_RGB: assert property (@(posedge clk) disable iff (rst)
    load && use_direct && !cfg_bgr |=>
      out_pixel[23:0] == {$past(up_rgb_word[7:0]), $past(up_rgb_word[15:8]),
                          $past(up_rgb_word[23:16])});                                // R4
  AST_TABLE_BGR: assert property (@(posedge clk) disable iff (rst)
    load && !use_direct && cfg_bgr |=>
      out_pixel[23:0] == {$past(pal_rgb.b), $past(pal_rgb.g), $past(pal_rgb.r)});     // R3

endmodule

// File: rtl/pix_plane_mixer.sv
module pix_plane_mixer
  import pix_mix_pkg::*;
#(
  parameter int         IDX_W      = 8,
  parameter int         MAX_W      = 1024,
  parameter logic [7:0] DIRECT_TAG = 8'h03
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_bgr,
  input  logic [$clog2(MAX_W):0] cfg_width,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [IDX_W-1:0]       in_index,
  input  logic [31:0]            in_direct,
  input  logic [31:0]            in_ctrl,
  output logic [IDX_W-1:0]       pal_addr,
  input  logic [23:0]            pal_rgb,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [31:0]            out_pixel,
  output logic                   out_eol
);

  logic             line_last;
  logic             accept;
  logic             s1_valid;
  logic [IDX_W-1:0] s1_idx;
  logic [23:0]      s1_rgb_word;
  logic [7:0]       s1_tag;
  logic             s1_eol;
  logic             down_en;
  rgb_t             pal_c;
  logic             ctrl_unused_bits;

  assign ctrl_unused_bits = ^{in_ctrl[23:0], in_direct[31:24]};
  assign accept   = in_valid && in_ready;
  assign pal_addr = s1_idx;
  assign pal_c    = rgb_t'(pal_rgb);

  pix_line_pos #(.MAX_W(MAX_W)) u_pos (
    .clk       (clk),
    .rst       (rst),
    .cfg_width (cfg_width),
    .adv       (accept),
    .last      (line_last)
  );

  pix_in_stage #(.IDX_W(IDX_W)) u_in (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_idx      (in_index),
    .in_rgb_word (in_direct[23:0]),
    .in_tag      (in_ctrl[31:24]),
    .in_eol      (line_last),
    .down_en     (down_en),
    .s1_valid    (s1_valid),
    .s1_idx      (s1_idx),
    .s1_rgb_word (s1_rgb_word),
    .s1_tag      (s1_tag),
    .s1_eol      (s1_eol)
  );

  pix_sel_stage #(.DIRECT_TAG(DIRECT_TAG)) u_sel (
    .clk         (clk),
    .rst         (rst),
    .up_valid    (s1_valid),
    .up_tag      (s1_tag),
    .up_rgb_word (s1_rgb_word),
    .up_eol      (s1_eol),
    .pal_rgb     (pal_c),
    .cfg_bgr     (cfg_bgr),
    .down_en     (down_en),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_pixel   (out_pixel),
    .out_eol     (out_eol)
  );

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);                                        // R10
  AST_FLOW_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    s1_valid && out_ready |=> out_valid);                            // R9

endmodule

// File: tb/pix_plane_mixer_tb_top.sv
`timescale 1ns/1ps
module pix_plane_mixer_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_bgr;
  logic [10:0] cfg_width;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_index;
  logic [31:0] in_direct;
  logic [31:0] in_ctrl;
  logic [7:0]  pal_addr;
  logic [23:0] pal_rgb;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_pixel;
  logic        out_eol;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_px  [0:4095];
  logic        exp_eol [0:4095];
  logic        exp_dir [0:4095];

  always #2 clk = ~clk;

  // Arithmetic colour table model answering the lookup port.
  function automatic logic [23:0] palf(logic [7:0] a);
    return {a ^ 8'h5A, 8'(a + 8'd17), ~a};
  endfunction
  assign pal_rgb = palf(pal_addr);

  function automatic logic [31:0] model(logic [7:0] idx, logic [31:0] dw,
                                        logic [31:0] cw, logic bgr);
    logic [7:0] r, g, b;
    if (cw[31:24] == 8'h03) begin
      r = dw[7:0]; g = dw[15:8]; b = dw[23:16];
    end else begin
      {r, g, b} = palf(idx);
    end
    return bgr ? {8'h00, b, g, r} : {8'h00, r, g, b};
  endfunction

  function automatic logic [7:0] gidx(int t, int n, bit sweep);
    return sweep ? (8'(n) ^ 8'hA5) : 8'(n * 37 + t * 11);
  endfunction

  function automatic logic [31:0] gdir(int t, int n);
    return {8'(n) ^ 8'hC3, 8'(n * 13), 8'(n * 7 + t), 8'(n * 29 + 5)};
  endfunction

  function automatic logic [31:0] gctrl(int t, int n, bit sweep);
    logic [7:0] tag;
    if (sweep) tag = 8'(n);
    else begin
      case (n % 6)
        0: tag = 8'h03;
        1: tag = 8'h00;
        2: tag = 8'h02;
        3: tag = 8'h04;
        4: tag = 8'hFF;
        default: tag = 8'h83;
      endcase
    end
    return {tag, 8'(n * 3 + t), 8'(n ^ 77), 8'(n * 19)};
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!out_valid, "R1 out_valid after reset", 32'(out_valid), 32'h0);
    chk(in_ready,   "R1 in_ready after reset",  32'(in_ready),  32'h1);
  endtask

  task automatic run_line(input int t, input int count, input int width,
                          input bit bgr, input int rmode, input int vmode,
                          input bit sweep);
    int sent, wr, rd, bpos, effw, cyc, prev_lo;
    bit hold_pend, orv, iv;
    logic [31:0] held_px;
    logic held_eol;
    do_reset();
    cfg_width = 11'(width);
    cfg_bgr   = bgr;
    effw = (width == 0 || width > 1024) ? 1024 : width;
    sent = 0; wr = 0; rd = 0; bpos = 0; cyc = 0; prev_lo = 0; hold_pend = 0;
    held_px = '0; held_eol = 1'b0;
    while ((sent < count || rd < count) && cyc < 20000) begin
      @(negedge clk);
      if (hold_pend)
        chk(out_valid && out_pixel == held_px && out_eol == held_eol,
            "R10 output held under stall", out_pixel, held_px);
      if (rmode == 0)      orv = 1'b1;
      else if (rmode == 1) orv = (cyc % 3) != 2;
      else                 orv = !((cyc % 11) >= 4 && (cyc % 11) <= 7);
      iv = (sent < count) && (vmode == 0 || (cyc % 5) != 3);
      out_ready = orv;
      in_valid  = iv;
      in_index  = gidx(t, sent, sweep);
      in_direct = gdir(t, sent);
      in_ctrl   = gctrl(t, sent, sweep);
      #1;
      if (!orv && prev_lo >= 2)
        chk(!in_ready, "R10 in_ready low when both stages full", 32'(in_ready), 32'h0);
      if (rmode == 0 && vmode == 0 && iv)
        chk(in_ready, "R9 full-rate acceptance", 32'(in_ready), 32'h1);
      if (out_valid && orv) begin
        if (rd >= count) chk(1'b0, "R10 extra output pixel", out_pixel, 32'h0);
        else begin
          chk(out_pixel == exp_px[rd],
              exp_dir[rd] ? "R2/R4/R5 direct pixel" : "R3/R5 table pixel",
              out_pixel, exp_px[rd]);
          chk(out_pixel[31:24] == 8'h00, "R6 top byte", out_pixel, exp_px[rd]);
          chk(out_eol == exp_eol[rd], "R7/R8 end of line", 32'(out_eol), 32'(exp_eol[rd]));
          rd++;
        end
      end
      hold_pend = out_valid && !orv;
      held_px   = out_pixel;
      held_eol  = out_eol;
      if (iv && in_ready) begin
        exp_px[wr]  = model(in_index, in_direct, in_ctrl, bgr);
        exp_dir[wr] = (in_ctrl[31:24] == 8'h03);
        exp_eol[wr] = (bpos == effw - 1);
        bpos = (bpos == effw - 1) ? 0 : bpos + 1;
        wr++;
        sent++;
      end
      prev_lo = (!orv && iv) ? prev_lo + 1 : 0;
      cyc++;
    end
    chk(sent == count && rd == count, "R10 all pixels delivered", 32'(rd), 32'(count));
  endtask

  task automatic latency_test();
    logic [31:0] e;
    do_reset();
    cfg_width = 11'd8; cfg_bgr = 1'b0;
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1;
    in_index = 8'h42; in_direct = 32'hEE123456; in_ctrl = 32'h03ABCDEF;
    e = model(in_index, in_direct, in_ctrl, 1'b0);
    #1;
    chk(in_ready, "R9 accept first pixel", 32'(in_ready), 32'h1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(!out_valid, "R9 not visible after one edge", 32'(out_valid), 32'h0);
    @(negedge clk);
    #1;
    chk(out_valid && out_pixel == e, "R9 visible after second edge", out_pixel, e);
    @(negedge clk);
    #1;
    chk(!out_valid, "R9 pixel consumed once", 32'(out_valid), 32'h0);
  endtask

  pix_plane_mixer dut_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_bgr   (cfg_bgr),
    .cfg_width (cfg_width),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_index  (in_index),
    .in_direct (in_direct),
    .in_ctrl   (in_ctrl),
    .pal_addr  (pal_addr),
    .pal_rgb   (pal_rgb),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pixel (out_pixel),
    .out_eol   (out_eol)
  );

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_bgr = 1'b0; cfg_width = 11'd16; in_valid = 1'b0;
    in_index = '0; in_direct = '0; in_ctrl = '0; out_ready = 1'b0;
    latency_test();                                  // R9
    run_line(1, 64,   16,   1'b0, 0, 0, 1'b0);       // R2 R3 R5 R7 R9
    run_line(2, 60,   5,    1'b1, 1, 1, 1'b0);       // R5 R10
    run_line(3, 256,  256,  1'b0, 2, 0, 1'b1);       // R2 R3 sweep, R10 full stall
    run_line(4, 256,  256,  1'b1, 0, 1, 1'b1);       // R2 R3 R4 sweep in BGR
    run_line(5, 2048, 0,    1'b0, 1, 0, 1'b0);       // R8 width zero
    run_line(6, 1100, 1100, 1'b1, 0, 0, 1'b0);       // R8 width above limit
    run_line(7, 20,   1,    1'b0, 2, 0, 1'b0);       // R7 width one
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule